// File: doc/BRIEF.md
# Toggle-Write Interrupt Status Controller

This block holds the interrupt state of a serial-peripheral controller. Event lines from the receive and transmit FIFOs and from the transfer engine are captured into a sticky status word. A per-bit enable word masks that status, and one global-enable bit gates the result. Together they drive a single registered, level-sensitive interrupt line.

Software reaches the three registers through select strobes, a write enable and a 32-bit data word. A status write does not simply clear bits: it XORs the written word into the status. Writing 1 to a set bit clears it, and writing 1 to a clear bit forces it. The two receive conditions are levels and are captured again on every clock while they hold, so clearing them has no lasting effect until the FIFO state changes. All pins are plain control and status wires with no stream handshake. A write takes effect at the clock edge where it is seen, and there is no back-pressure.

Top module: `irq_toggle_ctrl`

## Requirements
- R1: After reset the status, enable and global-enable registers read 0 and `irq` is low.
- R2: A write with `sel_status` and `wr_en` high replaces the status with (status XOR `wdata`) at the next edge, when no event sets a bit in that cycle.
- R3: A one-cycle pulse on an event input sets its status bit and the bit stays set with no further event: receive overrun bit 5, transmit half-empty bit 6, transmit underrun bit 3, transmit empty bit 2.
- R4: A pulse on `ev_byte_done` sets both status bit 2 (transmit empty) and status bit 8 (receive not-empty).
- R5: While `ev_rx_not_empty` (bit 8) or `ev_rx_full` (bit 4) is high, a status write that toggles that bit leaves it reading 1. Once the level drops, the same toggle clears it.
- R6: When an event sets a bit in the same cycle as a status write toggling that bit, the bit is 1 afterwards.
- R7: A write with `sel_enable` stores `wdata` in the enable register, and the stored word is read back unchanged.
- R8: The global-enable register keeps only bit 31, and every other written bit reads back 0. `irq` is high exactly when some bit of (status AND enable) is 1 and global-enable bit 31 is 1.
- R9: `irq` is a register output. It takes its new value at the same clock edge at which the register write or event that changes it is captured.
- R10: `rdata` shows the status when `sel_status` is high, otherwise the enable word when `sel_enable` is high, otherwise the global-enable word when `sel_global` is high, and 0 when no select is high.
- R11: Select strobes and `wdata` with `wr_en` low change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_status | input | 1 | Selects the status register |
| sel_enable | input | 1 | Selects the enable register |
| sel_global | input | 1 | Selects the global-enable register |
| wr_en | input | 1 | Write strobe for the selected register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| ev_rx_not_empty | input | 1 | Level: receive FIFO holds data |
| ev_rx_full | input | 1 | Level: receive FIFO full |
| ev_rx_overrun | input | 1 | Pulse: received byte dropped |
| ev_tx_half_empty | input | 1 | Pulse: transmit FIFO half empty |
| ev_tx_underrun | input | 1 | Pulse: transmit underrun |
| ev_tx_empty | input | 1 | Pulse: transmit FIFO drained |
| ev_byte_done | input | 1 | Pulse: one byte shifted out and in |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a hardware set and a software toggle of the same bit landing in one clock. A plain read-modify-write sequence never produces it. The bench drives an event pulse and the status write on the same falling edge so that both are captured at one rising edge, and it does this with the bit already set, so a pure XOR would clear it. The level re-capture case is reached the same way: the receive-full level is held across a clearing write, then released and cleared again.

// File: rtl/irq_toggle_pkg.sv
package irq_toggle_pkg;
  localparam int unsigned REG_W        = 32;
  localparam int unsigned GIE_POS      = 31;
  localparam int unsigned POS_RX_AVAIL = 8;
  localparam int unsigned POS_TX_HALF  = 6;
  localparam int unsigned POS_RX_OVR   = 5;
  localparam int unsigned POS_RX_FULL  = 4;
  localparam int unsigned POS_TX_UNDR  = 3;
  localparam int unsigned POS_TX_EMPTY = 2;

  typedef struct packed {
    logic rx_avail;
    logic rx_full;
    logic rx_ovr;
    logic tx_half;
    logic tx_undr;
    logic tx_empty;
    logic byte_done;
  } irq_events_t;

  typedef enum logic [1:0] {
    SEL_NONE   = 2'd0,
    SEL_STATUS = 2'd1,
    SEL_ENABLE = 2'd2,
    SEL_GLOBAL = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_event_capture.sv
module irq_event_capture
  import irq_toggle_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  irq_events_t ev,
  output logic [W-1:0] set_vec
);
  // One row per event source: which status bit it drives.
  localparam int unsigned NSRC = 6;

  logic [NSRC-1:0] src_hit;
  int unsigned     src_pos [NSRC];

  always_comb begin
    src_pos[0] = POS_RX_AVAIL;
    src_pos[1] = POS_RX_FULL;
    src_pos[2] = POS_RX_OVR;
    src_pos[3] = POS_TX_HALF;
    src_pos[4] = POS_TX_UNDR;
    src_pos[5] = POS_TX_EMPTY;
  end

  // A finished byte implies data arrived and the transmit side drained.
  assign src_hit[0] = ev.rx_avail | ev.byte_done;
  assign src_hit[1] = ev.rx_full;
  assign src_hit[2] = ev.rx_ovr;
  assign src_hit[3] = ev.tx_half;
  assign src_hit[4] = ev.tx_undr;
  assign src_hit[5] = ev.tx_empty | ev.byte_done;

  always_comb begin
    set_vec = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (src_hit[s]) set_vec[src_pos[s]] = 1'b1;
    end
  end
endmodule

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         toggle_en,
  input  logic [W-1:0] toggle_val,
  input  logic [W-1:0] set_vec,
  output logic [W-1:0] status_q,
  output logic [W-1:0] status_d
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic flip;
    assign flip        = toggle_en & toggle_val[b];
    // Hardware set has priority over the software toggle.
    assign status_d[b] = set_vec[b] | (status_q[b] ^ flip);

    always_ff @(posedge clk) begin
      if (!rst_n) status_q[b] <= 1'b0;
      else        status_q[b] <= status_d[b];
    end
  end
endmodule

// File: rtl/irq_mask_out.sv
module irq_mask_out #(
  parameter int unsigned W       = 32,
  parameter int unsigned GIE_BIT = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_wr,
  input  logic         gie_wr,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] status_d,
  output logic [W-1:0] enable_q,
  output logic         gie_q,
  output logic         irq_q
);
  logic [W-1:0] enable_d;
  logic         gie_d;
  logic         irq_d;

  assign enable_d = en_wr  ? wdata          : enable_q;
  assign gie_d    = gie_wr ? wdata[GIE_BIT] : gie_q;
  // Built from next-state values so irq moves on the same edge as the registers.
  assign irq_d    = gie_d & (|(status_d & enable_d));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enable_q <= '0;
      gie_q    <= 1'b0;
      irq_q    <= 1'b0;
    end else begin
      enable_q <= enable_d;
      gie_q    <= gie_d;
      irq_q    <= irq_d;
    end
  end
endmodule

// File: rtl/irq_toggle_ctrl.sv
module irq_toggle_ctrl
  import irq_toggle_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel_status,
  input  logic        sel_enable,
  input  logic        sel_global,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ev_rx_not_empty,
  input  logic        ev_rx_full,
  input  logic        ev_rx_overrun,
  input  logic        ev_tx_half_empty,
  input  logic        ev_tx_underrun,
  input  logic        ev_tx_empty,
  input  logic        ev_byte_done,
  output logic        irq
);
  localparam int unsigned W = REG_W;

  irq_events_t  ev;
  logic [W-1:0] set_vec;
  logic [W-1:0] status_q;
  logic [W-1:0] status_d;
  logic [W-1:0] enable_q;
  logic         gie_q;
  logic         wr_status;
  logic         wr_enable;
  logic         wr_global;
  reg_sel_e     rsel;

  assign ev.rx_avail  = ev_rx_not_empty;
  assign ev.rx_full   = ev_rx_full;
  assign ev.rx_ovr    = ev_rx_overrun;
  assign ev.tx_half   = ev_tx_half_empty;
  assign ev.tx_undr   = ev_tx_underrun;
  assign ev.tx_empty  = ev_tx_empty;
  assign ev.byte_done = ev_byte_done;

  assign wr_status = wr_en & sel_status;
  assign wr_enable = wr_en & sel_enable;
  assign wr_global = wr_en & sel_global;

  irq_event_capture #(.W(W)) u_cap (
    .ev      (ev),
    .set_vec (set_vec)
  );

  irq_status_reg #(.W(W)) u_stat (
    .clk        (clk),
    .rst_n      (rst_n),
    .toggle_en  (wr_status),
    .toggle_val (wdata),
    .set_vec    (set_vec),
    .status_q   (status_q),
    .status_d   (status_d)
  );

  irq_mask_out #(.W(W), .GIE_BIT(GIE_POS)) u_mask (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_wr    (wr_enable),
    .gie_wr   (wr_global),
    .wdata    (wdata),
    .status_d (status_d),
    .enable_q (enable_q),
    .gie_q    (gie_q),
    .irq_q    (irq)
  );

  always_comb begin
    if (sel_status)      rsel = SEL_STATUS;
    else if (sel_enable) rsel = SEL_ENABLE;
    else if (sel_global) rsel = SEL_GLOBAL;
    else                 rsel = SEL_NONE;
  end

  always_comb begin
    unique case (rsel)
      SEL_STATUS: rdata = status_q;
      SEL_ENABLE: rdata = enable_q;
      SEL_GLOBAL: begin
        rdata          = '0;
        rdata[GIE_POS] = gie_q;
      end
      default:    rdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_toggle_checker.sv
module irq_toggle_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_status,
  input logic [31:0] wdata,
  input logic [31:0] set_vec,
  input logic [31:0] status_q,
  input logic [31:0] enable_q,
  input logic        gie_q,
  input logic        ev_rx_not_empty,
  input logic        ev_byte_done,
  input logic        irq
);
  p_xor_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status && set_vec == 32'd0) |=> status_q == ($past(status_q) ^ $past(wdata)));

  for (genvar b = 0; b < 32; b++) begin : g_chk
    p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (status_q[b] && !(wr_status && wdata[b])) |=> status_q[b]);
    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[b] |=> status_q[b]);
  end

  p_byte_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_byte_done |=> (status_q[2] && status_q[8]));

  p_level_recapture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ev_rx_not_empty |=> status_q[8]);

  p_irq_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (gie_q && ((status_q & enable_q) != 32'd0)));

  p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_q |-> !irq);
endmodule

bind irq_toggle_ctrl irq_toggle_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .wr_status       (wr_status),
  .wdata           (wdata),
  .set_vec         (set_vec),
  .status_q        (status_q),
  .enable_q        (enable_q),
  .gie_q           (gie_q),
  .ev_rx_not_empty (ev_rx_not_empty),
  .ev_byte_done    (ev_byte_done),
  .irq             (irq)
);

// File: tb/sim_irq_toggle_ctrl.sv
module sim_irq_toggle_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel_status = 1'b0, sel_enable = 1'b0, sel_global = 1'b0, wr_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        ev_rx_not_empty = 1'b0, ev_rx_full = 1'b0, ev_rx_overrun = 1'b0;
  logic        ev_tx_half_empty = 1'b0, ev_tx_underrun = 1'b0, ev_tx_empty = 1'b0;
  logic        ev_byte_done = 1'b0;
  logic        irq;
  int          checks = 0;
  int          fails = 0;

  localparam int S_NONE = 0, S_STAT = 1, S_EN = 2, S_GIE = 3;

  always #5 clk = ~clk;

  irq_toggle_ctrl u0 (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic set_sel(int s);
    sel_status = (s == S_STAT);
    sel_enable = (s == S_EN);
    sel_global = (s == S_GIE);
  endtask

  // Drive at falling edge, captured at next rising edge, released at the falling edge after.
  task automatic wr(int s, logic [31:0] d);
    @(negedge clk);
    set_sel(s); wr_en = 1'b1; wdata = d;
    @(negedge clk);
    set_sel(S_NONE); wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(int s, output logic [31:0] d);
    set_sel(s); #1; d = rdata; set_sel(S_NONE);
  endtask

  task automatic clear_all();
    logic [31:0] v;
    rd(S_STAT, v);
    wr(S_STAT, v);
    wr(S_EN, 32'd0);
    wr(S_GIE, 32'd0);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(S_STAT, v); chk("R1 status", v, 0);
    rd(S_EN, v);   chk("R1 enable", v, 0);
    rd(S_GIE, v);  chk("R1 global", v, 0);
    chk("R1 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_xor();
    logic [31:0] v;
    wr(S_STAT, 32'hA000_0081);
    rd(S_STAT, v); chk("R2 set by toggle", v, 32'hA000_0081);
    wr(S_STAT, 32'h2000_0003);
    rd(S_STAT, v); chk("R2 mixed toggle", v, 32'h8000_0082);
    wr(S_STAT, 32'h8000_0082);
    rd(S_STAT, v); chk("R2 cleared", v, 0);
  endtask

  task automatic t_pulses();
    logic [31:0] v;
    @(negedge clk);
    ev_rx_overrun = 1; ev_tx_half_empty = 1; ev_tx_underrun = 1; ev_tx_empty = 1;
    @(negedge clk);
    ev_rx_overrun = 0; ev_tx_half_empty = 0; ev_tx_underrun = 0; ev_tx_empty = 0;
    repeat (3) @(negedge clk);
    rd(S_STAT, v); chk("R3 pulse bits sticky", v, 32'h0000_006C);
    clear_all();
  endtask

  task automatic t_byte_done();
    logic [31:0] v;
    @(negedge clk); ev_byte_done = 1;
    @(negedge clk); ev_byte_done = 0;
    rd(S_STAT, v); chk("R4 byte done", v, 32'h0000_0104);
    clear_all();
  endtask

  task automatic t_level();
    logic [31:0] v;
    @(negedge clk); ev_rx_full = 1; ev_rx_not_empty = 1;
    @(negedge clk);
    wr(S_STAT, 32'h0000_0110);
    rd(S_STAT, v); chk("R5 level recaptured", v, 32'h0000_0110);
    ev_rx_full = 0; ev_rx_not_empty = 0;
    @(negedge clk);
    wr(S_STAT, 32'h0000_0110);
    rd(S_STAT, v); chk("R5 cleared after level drop", v, 0);
  endtask

  task automatic t_set_wins();
    logic [31:0] v;
    wr(S_STAT, 32'h0000_0008);
    @(negedge clk);
    set_sel(S_STAT); wr_en = 1; wdata = 32'h0000_0008; ev_tx_underrun = 1;
    @(negedge clk);
    set_sel(S_NONE); wr_en = 0; wdata = 0; ev_tx_underrun = 0;
    rd(S_STAT, v); chk("R6 set beats toggle", v, 32'h0000_0008);
    clear_all();
  endtask

  task automatic t_enable_global();
    logic [31:0] v;
    wr(S_EN, 32'h5A5A_C3C3);
    rd(S_EN, v);  chk("R7 enable readback", v, 32'h5A5A_C3C3);
    wr(S_GIE, 32'hFFFF_FFFF);
    rd(S_GIE, v); chk("R8 global keeps bit 31", v, 32'h8000_0000);
    wr(S_GIE, 32'h7FFF_FFFF);
    rd(S_GIE, v); chk("R8 global low bits ignored", v, 0);
    clear_all();
  endtask

  task automatic t_irq();
    wr(S_EN, 32'h0000_0020);
    wr(S_GIE, 32'h8000_0000);
    chk("R8 no pending no irq", {31'd0, irq}, 0);
    @(negedge clk); ev_tx_underrun = 1;       // bit 3, masked
    @(negedge clk); ev_tx_underrun = 0;
    chk("R8 masked event", {31'd0, irq}, 0);
    ev_rx_overrun = 1;                         // bit 5, enabled
    @(posedge clk); #1;
    chk("R9 irq same edge", {31'd0, irq}, 1);
    @(negedge clk); ev_rx_overrun = 0;
    wr(S_GIE, 32'h0);
    chk("R8 global gate off", {31'd0, irq}, 0);
    wr(S_GIE, 32'h8000_0000);
    chk("R8 global gate on", {31'd0, irq}, 1);
    wr(S_STAT, 32'h0000_0020);
    chk("R8 cleared by toggle", {31'd0, irq}, 0);
    clear_all();
  endtask

  task automatic t_no_write();
    logic [31:0] v;
    @(negedge clk);
    sel_status = 1; sel_enable = 1; sel_global = 1; wdata = 32'hFFFF_FFFF;
    @(negedge clk);
    sel_status = 1; sel_enable = 0; sel_global = 0; #1;
    chk("R11 status untouched", rdata, 0);
    chk("R10 status priority", rdata, 0);
    sel_status = 0; sel_enable = 1; #1; chk("R11 enable untouched", rdata, 0);
    sel_enable = 0; sel_global = 1; #1; chk("R11 global untouched", rdata, 0);
    sel_global = 0; wdata = 0;
    wr(S_STAT, 32'h0000_0001);
    wr(S_EN, 32'h0000_0002);
    sel_status = 1; sel_enable = 1; #1; chk("R10 status over enable", rdata, 32'h1);
    sel_status = 0; sel_global = 1; #1; chk("R10 enable over global", rdata, 32'h2);
    sel_enable = 0; sel_global = 0; #1; chk("R10 no select reads 0", rdata, 0);
    clear_all();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_xor();
    t_pulses();
    t_byte_done();
    t_level();
    t_set_wins();
    t_enable_global();
    t_irq();
    t_no_write();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule